// File: doc/BRIEF.md
# Gated Period Timer with Compare Reset

This block is a 16-bit up-counter that advances on a count strobe, one system-clock cycle at a time. The strobe can be qualified by an external gate pin. The pin passes through a synchronizer, and a polarity select chooses whether a high or a low gate level lets counting proceed. The synchronized gate level is available as a status output.

A compare register is checked against the count in every cycle. When trigger mode is on and a match begins, the block does three things. It raises a one-cycle event pulse. It clears the counter, so the compare value sets the counting period. It raises a conversion-start strobe when the converter-enable input is high. This reset never sets the overflow flag. The flag is set only when normal counting wraps the counter, and it stays set until software clears it.

A single write port loads the count, the compare value or the overflow flag. A write to the count always takes priority over a trigger reset in the same cycle.

Top module: `gated_period_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, count, compare, ovf_flag, gate_sync, special_evt and conv_start are all zero.
- R2: With gate_en low, the counter advances by one on each clock edge where cnt_tick is high. On edges where cnt_tick is low it keeps its value.
- R3: With gate_en high, a tick advances the counter only when gate_sync equals gate_pol. Otherwise the counter holds its value (gate_pol 1 counts on a high gate, gate_pol 0 counts on a low gate).
- R4: gate_sync follows gate_pin after two clock edges. A pin change therefore affects qualification only from the second edge on.
- R5: A tick with the count at 0xFFFF wraps it to 0x0000 and sets ovf_flag. The flag stays set until a flag write with wr_data bit 0 equal to 0.
- R6: With trig_mode high, a match (count equal to compare) that was not present in the previous cycle clears the count at the next edge. At that same edge special_evt goes high for exactly one cycle.
- R7: A trigger reset never sets ovf_flag, even when the compare value is 0xFFFF.
- R8: A count write on the edge where a trigger reset would happen loads the written value instead of zero. special_evt still pulses.
- R9: conv_start pulses together with special_evt when conv_en is high in the trigger cycle. It stays low when conv_en is low.
- R10: An event fires only when a match begins. A match that persists does not fire again. A match that already exists when trig_mode is turned on does not fire.
- R11: wr_sel selects the target of a write: 0 loads the count, 1 loads compare, 2 loads ovf_flag from wr_data bit 0. A count write overrides a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count strobe, one per count-clock rising edge |
| gate_pin | input | 1 | Asynchronous external gate |
| gate_en | input | 1 | Enables gate qualification |
| gate_pol | input | 1 | Active gate level |
| trig_mode | input | 1 | Enables compare-triggered reset |
| conv_en | input | 1 | Allows the conversion-start strobe |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 compare, 2 flag |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current count |
| compare | output | 16 | Compare/period value |
| ovf_flag | output | 1 | Sticky overflow flag |
| gate_sync | output | 1 | Synchronized gate level |
| special_evt | output | 1 | One-cycle trigger pulse |
| conv_start | output | 1 | One-cycle conversion-start strobe |

## Verification
Writes and qualified ticks show on count one edge after they are sampled. A trigger appears as a cleared count together with special_evt and conv_start one edge after the cycle in which the match is first visible. A pin change reaches gate_sync two edges later. The driver changes inputs just after a rising edge. After each edge it queues the values due at that edge, and the monitor compares them at the following falling edge, so every check samples the exact cycle its result is due.

// File: rtl/gated_period_timer.sv
module gated_period_timer #(
  parameter int W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         gate_pin,
  input  logic         gate_en,
  input  logic         gate_pol,
  input  logic         trig_mode,
  input  logic         conv_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         ovf_flag,
  output logic         gate_sync,
  output logic         special_evt,
  output logic         conv_start
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  logic [SYNC_STAGES-1:0] gsr;
  logic match, match_q;

  assign gate_sync = gsr[SYNC_STAGES-1];

  wire wr_cnt   = wr_en && (wr_sel == 2'd0);
  wire wr_cmp   = wr_en && (wr_sel == 2'd1);
  wire wr_flag  = wr_en && (wr_sel == 2'd2);
  wire count_ok = cnt_tick && (!gate_en || (gate_sync == gate_pol));
  wire evt_hit  = trig_mode && match && !match_q;

  assign match = (count == compare);

  always_ff @(posedge clk) begin
    if (!rst_n) gsr <= '0;
    else        gsr <= {gsr[SYNC_STAGES-2:0], gate_pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      compare     <= '0;
      ovf_flag    <= 1'b0;
      match_q     <= 1'b0;
      special_evt <= 1'b0;
      conv_start  <= 1'b0;
    end else begin
      match_q     <= match;
      special_evt <= evt_hit;
      conv_start  <= evt_hit && conv_en;
      if (wr_cmp) compare <= wr_data;
      if (wr_cnt)
        count <= wr_data;
      else if (evt_hit)
        count <= '0;
      else if (count_ok)
        count <= count + ONE;
      if (wr_flag)
        ovf_flag <= wr_data[0];
      else if (!wr_cnt && !evt_hit && count_ok && count == TOP)
        ovf_flag <= 1'b1;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_ok && !wr_en && !evt_hit) |=> $stable(count));

  a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(wr_flag) || ($past(count) == TOP && $past(count_ok))));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !wr_cnt) |=> (count == '0 && special_evt));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !wr_flag) |=> !$rose(ovf_flag));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && wr_cnt) |=> (count == $past(wr_data)));

  a_r9_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> special_evt);

  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    special_evt |=> !special_evt);

endmodule

// File: tb/gated_period_timer_test.sv
module gated_period_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 0, gate_pin = 0, gate_en = 0, gate_pol = 0;
  logic trig_mode = 0, conv_en = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count, compare;
  logic ovf_flag, gate_sync, special_evt, conv_start;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  gated_period_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate_pin(gate_pin),
    .gate_en(gate_en), .gate_pol(gate_pol), .trig_mode(trig_mode),
    .conv_en(conv_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .compare(compare), .ovf_flag(ovf_flag),
    .gate_sync(gate_sync), .special_evt(special_evt), .conv_start(conv_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return count;
      1: return {15'd0, special_evt};
      2: return {15'd0, conv_start};
      3: return {15'd0, ovf_flag};
      4: return {15'd0, gate_sync};
      default: return compare;
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s: signal %0d actual %h expected %h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_val(int kind, logic [15:0] val, string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      cnt_tick = 1; step(); cnt_tick = 0;
    end
  endtask

  task automatic write(logic [1:0] sel, logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    expect_val(0, 16'h0, "R1"); expect_val(5, 16'h0, "R1"); expect_val(3, 0, "R1");
    expect_val(4, 0, "R1"); expect_val(1, 0, "R1"); expect_val(2, 0, "R1");

    tick(1); expect_val(0, 16'd1, "R2");
    tick(2); expect_val(0, 16'd3, "R2");
    step(); step(); expect_val(0, 16'd3, "R2");

    write(0, 16'h1234); expect_val(0, 16'h1234, "R11");
    cnt_tick = 1; write(0, 16'h0100); cnt_tick = 0;
    expect_val(0, 16'h0100, "R11");
    write(1, 16'h0055); expect_val(5, 16'h0055, "R11");

    write(0, 16'h0);
    gate_en = 1; gate_pol = 1; gate_pin = 0;
    step(); step();
    tick(2); expect_val(0, 16'd0, "R3");
    gate_pin = 1;
    step(); expect_val(4, 0, "R4");
    step(); expect_val(4, 1, "R4");
    tick(1); expect_val(0, 16'd1, "R3");
    tick(1); expect_val(0, 16'd2, "R3");
    gate_pol = 0;
    tick(1); expect_val(0, 16'd2, "R3");
    gate_pin = 0;
    step(); step(); expect_val(4, 0, "R4");
    tick(1); expect_val(0, 16'd3, "R3");
    gate_en = 0;

    write(0, 16'hFFFE);
    tick(1); expect_val(0, 16'hFFFF, "R5"); expect_val(3, 0, "R5");
    tick(1); expect_val(0, 16'h0000, "R5"); expect_val(3, 1, "R5");
    tick(2); expect_val(0, 16'd2, "R5"); expect_val(3, 1, "R5");
    write(2, 16'h0); expect_val(3, 0, "R5");

    trig_mode = 1;
    write(1, 16'd3);
    write(0, 16'd0);
    tick(3); expect_val(0, 16'd3, "R6"); expect_val(1, 0, "R6");
    step(); expect_val(0, 16'd0, "R6"); expect_val(1, 1, "R6"); expect_val(2, 0, "R9");
    step(); expect_val(1, 0, "R6");
    conv_en = 1;
    tick(3); expect_val(0, 16'd3, "R6");
    step(); expect_val(0, 16'd0, "R6"); expect_val(1, 1, "R6"); expect_val(2, 1, "R9");
    step(); expect_val(2, 0, "R9"); expect_val(1, 0, "R6");

    write(1, 16'hFFFF);
    write(0, 16'hFFFE);
    tick(1); expect_val(0, 16'hFFFF, "R7");
    step(); expect_val(0, 16'h0, "R7"); expect_val(1, 1, "R7"); expect_val(3, 0, "R7");
    step(); expect_val(3, 0, "R7");

    write(1, 16'h0010);
    write(0, 16'h000F);
    tick(1); expect_val(0, 16'h0010, "R8");
    write(0, 16'h0200); expect_val(0, 16'h0200, "R8"); expect_val(1, 1, "R8");
    step(); expect_val(0, 16'h0200, "R8"); expect_val(1, 0, "R8");

    write(1, 16'h0);
    write(0, 16'h0); expect_val(1, 0, "R10");
    step(); expect_val(1, 1, "R10"); expect_val(0, 16'h0, "R10");
    step(); expect_val(1, 0, "R10");
    step(); expect_val(1, 0, "R10");
    trig_mode = 0;
    write(1, 16'd5);
    write(0, 16'd5);
    step(); expect_val(1, 0, "R10");
    trig_mode = 1;
    step(); expect_val(1, 0, "R10"); expect_val(0, 16'd5, "R10");
    step(); expect_val(1, 0, "R10"); expect_val(0, 16'd5, "R10");

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule